// File: doc/BRIEF.md
# Clock, Reset and Stop Controller

This block is the system control logic that sits between the board-level clock and reset pins and the processor. It produces the processor clock enable by dividing a fast reference tick, or, when the low-speed source is chosen, by passing the slow sub-clock tick. The fast tick stands for a 192 MHz reference. The divide ratio can be set from 6 to 16 and comes out of reset at 8, which gives 24 MHz.

The external reset pin is active low. It passes through a two-flop synchronizer and a low-time filter, so a pulse that is too short is rejected. After the pin is released, the internal reset is held for a further time that depends on the input-frequency strap: 1.9 ms for a 13 MHz input (strap 0) and 2.0 ms for a 12 MHz input (strap 1). Both times are counted in reference ticks.

A sleep pin is synchronized in the same way. Each of its edges produces one request pulse: a rising edge asks to enter stop mode and a falling edge asks to leave it. From a stop request until the host acknowledges a wake request, the clock enable is held low.

Top module: `clkrst_ctrl`

## Requirements
- R1: After the reset pin rises, `sys_rst` stays high for a hold of `HOLD13_TICKS` reference ticks when `freq_strap` is 0, or `HOLD12_TICKS` when it is 1. With a tick every clock and two synchronizer stages, `sys_rst` falls right after the (3+hold)-th rising clock edge following the pin's rise.
- R2: A low pulse on `rst_pin_n` lasting fewer than `MIN_LOW_TICKS` reference ticks leaves `sys_rst` low. A low pulse lasting `MIN_LOW_TICKS` or more asserts it.
- R3: With the fast source selected, `cpu_ce` is a one-clock pulse once every R reference ticks. R comes out of internal reset as 8. Clocks without a tick do not count.
- R4: A ratio write (`div_we`) whose value lies outside 6..16 is discarded, and the running period is unchanged.
- R5: An accepted ratio write completes the period in progress at the old ratio. The new ratio applies from the next divided-clock boundary onward.
- R6: With the slow source selected (source bit 1), `cpu_ce` repeats `slow_tick` one clock later, and fast ticks produce no enable pulse.
- R7: A write with `src_we` sets the source bit from `src_val`, which overrides the strap. Writing 0 returns the enable to the divided fast tick.
- R8: A rising edge on `sleep_pin` produces exactly one one-clock `stop_req` pulse, three rising clock edges after the pin edge. From then on `cpu_ce` stays low.
- R9: A falling edge on `sleep_pin` produces exactly one one-clock `wake_req` pulse. `cpu_ce` stays low until `wake_ack` is seen while a wake is pending, and then resumes.
- R10: `sys_rst` is high from power-up reset until the first hold completes, and `cpu_ce` stays low whenever `sys_rst` is high.
- R11: Every internal reset restores the ratio to 8 and reloads the source bit from `src_strap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Power-up reset from the supply monitor, active low |
| ref_tick | input | 1 | One pulse per 192 MHz reference period |
| slow_tick | input | 1 | One pulse per sub-clock period |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| sleep_pin | input | 1 | Sleep pin, asynchronous |
| freq_strap | input | 1 | Input frequency: 0 = 13 MHz, 1 = 12 MHz |
| src_strap | input | 1 | Source at reset: 0 = divided fast tick, 1 = slow tick |
| src_we | input | 1 | Source override write strobe |
| src_val | input | 1 | Source override value |
| div_we | input | 1 | Divide ratio write strobe |
| div_val | input | 5 | Divide ratio, accepted in 6..16 |
| wake_ack | input | 1 | Host acknowledge of a wake request |
| cpu_ce | output | 1 | Processor clock enable |
| sys_rst | output | 1 | Synchronous internal reset, active high |
| stop_req | output | 1 | One-clock request to enter stop mode |
| wake_req | output | 1 | One-clock request to leave stop mode |

## Verification
The bench aims at the filter boundary with pulses one tick shorter than the minimum and exactly at the minimum. A filter that is off by one would either reset on a glitch or miss a valid reset. It measures the hold for both straps to the exact clock edge, which catches a swapped strap decode or a lost synchronizer stage.

A scoreboard compares the enable intervals around ratio writes. It would catch a ratio that takes effect mid-period (a short pulse), an out-of-range value that slips in, or gaps in the tick that are counted as ticks. The stop sequence checks that each edge gives a single pulse and that the enable stays gated until the acknowledge. A design that released on the wake edge alone would let the enable run early.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;
    localparam int unsigned DIV_W = 5;
    localparam logic [DIV_W-1:0] DIV_MIN = 5'd6;
    localparam logic [DIV_W-1:0] DIV_MAX = 5'd16;
    localparam logic [DIV_W-1:0] DIV_DEF = 5'd8;

    typedef enum logic [1:0] {
        RS_RUN  = 2'd0,
        RS_LOW  = 2'd1,
        RS_HOLD = 2'd2
    } rst_state_e;
endpackage

// File: rtl/clkrst_rst_seq.sv
module clkrst_rst_seq
    import clkrst_pkg::*;
#(
    parameter int unsigned MIN_LOW = 1920,
    parameter int unsigned HOLD13  = 364800,
    parameter int unsigned HOLD12  = 384000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic tick,
    input  logic pin_n,
    input  logic freq_sel,
    output logic rst_o
);
    localparam int unsigned HMAX   = (HOLD12 > HOLD13) ? HOLD12 : HOLD13;
    localparam int unsigned HCNT_W = $clog2(HMAX + 1);
    localparam int unsigned FCNT_W = $clog2(MIN_LOW + 1);

    typedef struct packed {
        logic [1:0]        sync;
        rst_state_e        st;
        logic [FCNT_W-1:0] fcnt;
        logic [HCNT_W-1:0] hcnt;
    } seq_t;

    localparam seq_t SEQ_RST = '{sync: 2'b00, st: RS_LOW, fcnt: '0, hcnt: '0};

    seq_t q, d;
    logic pin_hi;
    logic [HCNT_W-1:0] hold_last;

    always_comb begin
        d         = q;
        d.sync    = {q.sync[0], pin_n};
        pin_hi    = q.sync[1];
        hold_last = freq_sel ? HCNT_W'(HOLD12 - 1) : HCNT_W'(HOLD13 - 1);
        case (q.st)
            RS_RUN: begin
                if (pin_hi) begin
                    d.fcnt = '0;
                end else if (tick) begin
                    if (q.fcnt == FCNT_W'(MIN_LOW - 1)) begin
                        d.st   = RS_LOW;
                        d.fcnt = '0;
                    end else begin
                        d.fcnt = q.fcnt + 1'b1;
                    end
                end
            end
            RS_LOW: begin
                if (pin_hi) begin
                    d.st   = RS_HOLD;
                    d.hcnt = '0;
                end
            end
            RS_HOLD: begin
                if (!pin_hi) begin
                    d.st = RS_LOW;
                end else if (tick) begin
                    if (q.hcnt == hold_last) begin
                        d.st   = RS_RUN;
                        d.fcnt = '0;
                    end else begin
                        d.hcnt = q.hcnt + 1'b1;
                    end
                end
            end
            default: d.st = RS_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= SEQ_RST;
        else         q <= d;
    end

    assign rst_o = (q.st != RS_RUN);

    // R1: internal reset is released only while the synchronized pin is high
    assert_release_needs_pin_R1: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(rst_o) |-> $past(q.sync[1]));

    // R2: internal reset is raised only after the synchronized pin has been low
    assert_assert_needs_low_R2: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(rst_o) |-> !$past(q.sync[1]));
endmodule

// File: rtl/clkrst_ce_div.sv
module clkrst_ce_div
    import clkrst_pkg::*;
(
    input  logic             clk,
    input  logic             arst_n,
    input  logic             srst,
    input  logic             tick,
    input  logic             slow_tick,
    input  logic             src_strap,
    input  logic             src_we,
    input  logic             src_val,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_val,
    output logic             ce_o
);
    typedef struct packed {
        logic [DIV_W-1:0] ratio;
        logic             pend_v;
        logic [DIV_W-1:0] pend;
        logic [DIV_W-1:0] dcnt;
        logic             src;
        logic             ce;
    } div_t;

    localparam div_t DIV_RST = '{ratio: DIV_DEF, pend_v: 1'b0, pend: '0,
                                 dcnt: '0, src: 1'b0, ce: 1'b0};

    div_t q, d;
    logic wrap;
    logic val_ok;

    always_comb begin
        d      = q;
        wrap   = tick && (q.dcnt == q.ratio - DIV_W'(1));
        val_ok = (div_val >= DIV_MIN) && (div_val <= DIV_MAX);
        if (srst) begin
            d     = DIV_RST;
            d.src = src_strap;
        end else begin
            if (tick) begin
                if (wrap) begin
                    d.dcnt = '0;
                    if (q.pend_v) begin
                        d.ratio  = q.pend;
                        d.pend_v = 1'b0;
                    end
                end else begin
                    d.dcnt = q.dcnt + 1'b1;
                end
            end
            if (div_we && val_ok) begin
                d.pend_v = 1'b1;
                d.pend   = div_val;
            end
            if (src_we) d.src = src_val;
            d.ce = q.src ? slow_tick : wrap;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= DIV_RST;
        else         q <= d;
    end

    assign ce_o = q.ce;

    // R4: the active ratio never leaves the legal range
    assert_ratio_range_R4: assert property (@(posedge clk) disable iff (!arst_n)
        (q.ratio >= DIV_MIN) && (q.ratio <= DIV_MAX));

    // R5: the ratio changes only at a divided-clock boundary or by internal reset
    assert_ratio_at_edge_R5: assert property (@(posedge clk) disable iff (!arst_n)
        !$stable(q.ratio) |-> ($past(srst) ||
            ($past(tick) && ($past(q.dcnt) == $past(q.ratio) - DIV_W'(1)))));

    // R6: on the slow source the enable repeats the slow tick one clock later
    assert_slow_follow_R6: assert property (@(posedge clk) disable iff (!arst_n)
        ($past(q.src) && !$past(srst)) |-> (q.ce == $past(slow_tick)));
endmodule

// File: rtl/clkrst_stop_ctl.sv
module clkrst_stop_ctl (
    input  logic clk,
    input  logic arst_n,
    input  logic srst,
    input  logic pin,
    input  logic wake_ack,
    output logic stop_req,
    output logic wake_req,
    output logic stop_o
);
    typedef struct packed {
        logic [1:0] sync;
        logic       prev;
        logic       stop;
        logic       wpend;
        logic       sreq;
        logic       wreq;
    } stp_t;

    localparam stp_t STP_RST = '{sync: 2'b00, prev: 1'b0, stop: 1'b0,
                                 wpend: 1'b0, sreq: 1'b0, wreq: 1'b0};

    stp_t q, d;
    logic rise, fall;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], pin};
        d.prev = q.sync[1];
        rise   = q.sync[1] & ~q.prev;
        fall   = ~q.sync[1] & q.prev;
        d.sreq = 1'b0;
        d.wreq = 1'b0;
        if (srst) begin
            d.stop  = 1'b0;
            d.wpend = 1'b0;
        end else begin
            if (rise) begin
                d.sreq  = 1'b1;
                d.stop  = 1'b1;
                d.wpend = 1'b0;
            end
            if (fall) begin
                d.wreq = 1'b1;
                if (q.stop) d.wpend = 1'b1;
            end
            if (wake_ack && q.wpend) begin
                d.stop  = 1'b0;
                d.wpend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= STP_RST;
        else         q <= d;
    end

    assign stop_req = q.sreq;
    assign wake_req = q.wreq;
    assign stop_o   = q.stop;

    // R8: one pulse per rising sleep edge
    assert_stop_single_R8: assert property (@(posedge clk) disable iff (!arst_n)
        stop_req |=> !stop_req);

    // R9: one pulse per falling sleep edge
    assert_wake_single_R9: assert property (@(posedge clk) disable iff (!arst_n)
        wake_req |=> !wake_req);

    // R8: the two requests never coincide
    assert_req_exclusive_R8: assert property (@(posedge clk) disable iff (!arst_n)
        $onehot0({stop_req, wake_req}));

    // R9: stop mode ends only through an acknowledge or internal reset
    assert_stop_exit_R9: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(stop_o) |-> ($past(wake_ack) || $past(srst)));
endmodule

// File: rtl/clkrst_ctrl.sv
module clkrst_ctrl
    import clkrst_pkg::*;
#(
    parameter int unsigned MIN_LOW_TICKS = 1920,
    parameter int unsigned HOLD13_TICKS  = 364800,
    parameter int unsigned HOLD12_TICKS  = 384000
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             ref_tick,
    input  logic             slow_tick,
    input  logic             rst_pin_n,
    input  logic             sleep_pin,
    input  logic             freq_strap,
    input  logic             src_strap,
    input  logic             src_we,
    input  logic             src_val,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_val,
    input  logic             wake_ack,
    output logic             cpu_ce,
    output logic             sys_rst,
    output logic             stop_req,
    output logic             wake_req
);
    logic rst_int;
    logic ce_raw;
    logic stop_act;

    clkrst_rst_seq #(
        .MIN_LOW (MIN_LOW_TICKS),
        .HOLD13  (HOLD13_TICKS),
        .HOLD12  (HOLD12_TICKS)
    ) u_rst (
        .clk      (clk),
        .arst_n   (arst_n),
        .tick     (ref_tick),
        .pin_n    (rst_pin_n),
        .freq_sel (freq_strap),
        .rst_o    (rst_int)
    );

    clkrst_ce_div u_div (
        .clk       (clk),
        .arst_n    (arst_n),
        .srst      (rst_int),
        .tick      (ref_tick),
        .slow_tick (slow_tick),
        .src_strap (src_strap),
        .src_we    (src_we),
        .src_val   (src_val),
        .div_we    (div_we),
        .div_val   (div_val),
        .ce_o      (ce_raw)
    );

    clkrst_stop_ctl u_stop (
        .clk      (clk),
        .arst_n   (arst_n),
        .srst     (rst_int),
        .pin      (sleep_pin),
        .wake_ack (wake_ack),
        .stop_req (stop_req),
        .wake_req (wake_req),
        .stop_o   (stop_act)
    );

    assign cpu_ce  = ce_raw & ~stop_act & ~rst_int;
    assign sys_rst = rst_int;
endmodule

// File: tb/test_clkrst_ctrl.sv
module test_clkrst_ctrl;
    localparam int MINL = 8;
    localparam int H13  = 40;
    localparam int H12  = 52;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       arst_n = 1'b0, ref_tick = 1'b1, slow_tick = 1'b0;
    logic       rst_pin_n = 1'b0, sleep_pin = 1'b0;
    logic       freq_strap = 1'b0, src_strap = 1'b0;
    logic       src_we = 1'b0, src_val = 1'b0, div_we = 1'b0, wake_ack = 1'b0;
    logic [4:0] div_val = 5'd0;
    logic       cpu_ce, sys_rst, stop_req, wake_req;

    int    total = 0, bad = 0;
    int    cyc = 0, last_ce = 0, mon_iv = 0, ce_cnt = 0;
    int    exp_q[$];
    string tag_q[$];
    logic  tick_toggle = 1'b0;

    clkrst_ctrl #(
        .MIN_LOW_TICKS (MINL),
        .HOLD13_TICKS  (H13),
        .HOLD12_TICKS  (H12)
    ) i_clkrst_ctrl (
        .clk(clk), .arst_n(arst_n), .ref_tick(ref_tick), .slow_tick(slow_tick),
        .rst_pin_n(rst_pin_n), .sleep_pin(sleep_pin), .freq_strap(freq_strap),
        .src_strap(src_strap), .src_we(src_we), .src_val(src_val),
        .div_we(div_we), .div_val(div_val), .wake_ack(wake_ack),
        .cpu_ce(cpu_ce), .sys_rst(sys_rst), .stop_req(stop_req), .wake_req(wake_req)
    );

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (tick_toggle) ref_tick <= ~ref_tick;

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // scoreboard monitor: interval between enable pulses
    always @(negedge clk) begin
        if (arst_n && cpu_ce === 1'b1) begin
            mon_iv  = cyc - last_ce;
            last_ce = cyc;
            if (exp_q.size() > 0) chk(tag_q.pop_front(), mon_iv, exp_q.pop_front());
        end
    end

    task automatic expect_iv(input string tag, input int v);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic wait_ce();
        do @(negedge clk); while (cpu_ce !== 1'b1);
        #1;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic count_ce(input int n);
        ce_cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cpu_ce === 1'b1) ce_cnt++;
        end
    endtask

    task automatic release_check(input string tag, input int hold);
        @(negedge clk);
        rst_pin_n = 1'b1;
        count_ce(2 + hold);
        chk("R10 enable during hold", ce_cnt, 0);
        chk(tag, int'(sys_rst), 1);
        @(negedge clk);
        chk(tag, int'(sys_rst), 0);
    endtask

    task automatic write_div(input logic [4:0] v);
        div_val = v;
        div_we  = 1'b1;
        @(negedge clk);
        div_we  = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        arst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset state sys_rst", int'(sys_rst), 1);
        chk("R10 reset state cpu_ce", int'(cpu_ce), 0);
        chk("R8 reset state stop_req", int'(stop_req), 0);
        chk("R9 reset state wake_req", int'(wake_req), 0);
        repeat (5) @(negedge clk);
        release_check("R1 hold 13MHz", H13);

        // R3 default ratio
        wait_ce();
        repeat (3) expect_iv("R3 default period", 8);
        drain();
        // R3 ticks with gaps
        wait_ce();
        tick_toggle = 1'b1;
        wait_ce();
        repeat (2) expect_iv("R3 gapped ticks", 16);
        drain();
        tick_toggle = 1'b0;
        @(negedge clk);
        ref_tick = 1'b1;

        // R4 out of range
        wait_ce();
        repeat (2) expect_iv("R4 value 5 ignored", 8);
        write_div(5'd5);
        drain();
        wait_ce();
        repeat (2) expect_iv("R4 value 17 ignored", 8);
        write_div(5'd17);
        drain();

        // R5 change at boundary
        wait_ce();
        expect_iv("R5 old period kept", 8);
        repeat (2) expect_iv("R5 new ratio 12", 12);
        write_div(5'd12);
        drain();
        wait_ce();
        expect_iv("R5 old period kept", 12);
        repeat (2) expect_iv("R5 new ratio 6", 6);
        write_div(5'd6);
        drain();
        wait_ce();
        expect_iv("R5 old period kept", 6);
        repeat (2) expect_iv("R5 new ratio 16", 16);
        write_div(5'd16);
        drain();

        // R8 stop entry
        @(negedge clk);
        sleep_pin = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 stop_req pulse", int'(stop_req), 1);
        chk("R8 no wake_req", int'(wake_req), 0);
        @(negedge clk);
        chk("R8 stop_req single", int'(stop_req), 0);
        count_ce(40);
        chk("R8 enable held low", ce_cnt, 0);

        // R9 wake handshake
        sleep_pin = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 wake_req pulse", int'(wake_req), 1);
        chk("R9 no stop_req", int'(stop_req), 0);
        @(negedge clk);
        chk("R9 wake_req single", int'(wake_req), 0);
        count_ce(30);
        chk("R9 enable low before ack", ce_cnt, 0);
        wake_ack = 1'b1;
        @(negedge clk);
        wake_ack = 1'b0;
        count_ce(40);
        chk("R9 enable resumes after ack", int'(ce_cnt > 0), 1);

        // R2 filter, R1 hold at 12 MHz, with slow source strap
        freq_strap = 1'b1;
        src_strap  = 1'b1;
        @(negedge clk);
        rst_pin_n = 1'b0;
        repeat (MINL - 2) @(negedge clk);
        @(negedge clk);
        rst_pin_n = 1'b1;
        repeat (15) @(negedge clk);
        chk("R2 short pulse ignored", int'(sys_rst), 0);
        @(negedge clk);
        rst_pin_n = 1'b0;
        repeat (MINL - 1) @(negedge clk);
        release_check("R1 R2 hold 12MHz after minimum pulse", H12);

        // R6 slow source
        count_ce(20);
        chk("R6 no enable from fast ticks", ce_cnt, 0);
        slow_tick = 1'b1;
        @(negedge clk);
        slow_tick = 1'b0;
        chk("R6 enable follows slow tick", int'(cpu_ce), 1);
        @(negedge clk);
        chk("R6 enable one clock wide", int'(cpu_ce), 0);

        // R7 override, R11 ratio restored to 8
        src_val = 1'b0;
        src_we  = 1'b1;
        @(negedge clk);
        src_we  = 1'b0;
        wait_ce();
        expect_iv("R7 fast source after override", 8);
        expect_iv("R11 ratio back to 8", 8);
        drain();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule